// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block turns outgoing memory offsets from the local side into 64-bit link-side addresses. The outbound region is split into a bank of equal windows. Software chooses one global window size, gives each window a translated base (a low word carrying an enable flag and a separate high word), and switches the whole mapping on with a global enable flag.

Each cycle a request may be presented as an offset into the outbound region. The block works out which window the offset falls in and the position inside that window. It checks that translation is on, that the window exists and that it is enabled. One cycle later it answers with the link address, which is the window base plus the inner position, or with an error flag. A simple register port with one-cycle read latency holds the configuration. The block does not generate any transactions itself.

Top module: `otw_xlate`

## Requirements
- R1: After reset the global enable reads 0, the size index reads 3 (8 MB windows), every window word reads 0 and rsp_valid is low.
- R2: Register map, by byte offset on reg_addr: 0x004 holds the global enable in bit 1; 0x030 holds the size index in bits [2:0]; window n has its low word at 0x200+8n and its high word at 0x204+8n. rdata shows the addressed word in the cycle after rd_en. Unused bits read 0. Addresses outside the map read 0, and writes to them change nothing.
- R3: Each cycle with req_valid high produces exactly one cycle of rsp_valid in the next cycle. rsp_valid stays low otherwise.
- R4: The window size is 2^(20+size index) bytes. The window number is req_offset divided by that size, and the inner position is the remainder.
- R5: A successful response gives rsp_addr = {high word, low word with bit 0 cleared} + inner position, computed at 64 bits with carry into the high word, and rsp_err = 0.
- R6: A request that lands in a window whose low-word bit 0 is 0 gets rsp_err = 1 and rsp_addr = 0.
- R7: While the global enable is 0, every request gets rsp_err = 1 and rsp_addr = 0.
- R8: A request whose window number is 32 or more gets rsp_err = 1 and rsp_addr = 0.
- R9: A size write applies only to requests in later cycles. A request presented in the same cycle as the size write uses the old size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, valid the cycle after rd_en |
| req_valid | input | 1 | Translate request strobe |
| req_offset | input | 32 | Offset into the outbound region |
| rsp_valid | output | 1 | Translate response strobe |
| rsp_err | output | 1 | Request refused (translation off, window missing or disabled) |
| rsp_addr | output | 64 | Translated link address, zero on error |

## Verification
The assertions assume that req_valid and the register strobes are 0 or 1 on every clock edge after reset. They also assume that a register write and a request may coincide, and that the ordering rule R9 decides the outcome in that case. The bench drives all inputs on the falling edge, so every value is settled before the rising edge that captures it. It reads rdata and the response only after the following falling edge. The one cycle that carries a size write and a request together is built on purpose, so that the old-size rule is exercised.

// File: rtl/otw_pkg.sv
package otw_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LINK_W  = 64;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned MB_LOG2 = 20;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINK_W-1:0] link_t;
  typedef logic [SIZE_W-1:0] size_t;

  // log2 of the window span in bytes
  function automatic logic [5:0] span_log2(input size_t sz);
    return 6'(MB_LOG2) + 6'(sz);
  endfunction

  function automatic word_t win_number(input word_t off, input size_t sz);
    return off >> span_log2(sz);
  endfunction

  function automatic word_t win_inner(input word_t off, input size_t sz);
    word_t keep;
    keep = (word_t'(1) << span_log2(sz)) - word_t'(1);
    return off & keep;
  endfunction

  function automatic link_t link_base(input word_t hi, input word_t lo);
    return {hi, lo[WORD_W-1:1], 1'b0};
  endfunction

  function automatic link_t link_addr(input word_t hi, input word_t lo, input word_t inner);
    return link_base(hi, lo) + {{(LINK_W-WORD_W){1'b0}}, inner};
  endfunction
endpackage

// File: rtl/otw_regs.sv
module otw_regs
  import otw_pkg::*;
#(
  parameter int NUM_WIN    = 32,
  parameter int REG_AW     = 12,
  parameter int RESET_SIZE = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [REG_AW-1:0]              reg_addr,
  input  word_t                          wdata,
  output word_t                          rdata,
  output logic                           xlate_on,
  output size_t                          size_idx,
  output logic                           size_write,
  output logic [NUM_WIN-1:0][WORD_W-1:0] win_lo,
  output logic [NUM_WIN-1:0][WORD_W-1:0] win_hi
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam logic [REG_AW-1:0] CTRL_OFS = REG_AW'(12'h004);
  localparam logic [REG_AW-1:0] SIZE_OFS = REG_AW'(12'h030);
  localparam logic [REG_AW-1:0] TBL_OFS  = REG_AW'(12'h200);
  localparam logic [REG_AW:0]   TBL_END  = (REG_AW+1)'(32'h200 + 8 * NUM_WIN);

  logic              hit_ctrl, in_tbl, tbl_hi;
  logic [REG_AW-1:0] tbl_rel;
  logic [IDX_W-1:0]  tbl_idx;
  logic [NUM_WIN-1:0] lo_we, hi_we;
  word_t             rd_word;

  assign hit_ctrl   = (reg_addr == CTRL_OFS);
  assign size_write = wr_en && (reg_addr == SIZE_OFS);
  assign in_tbl     = (reg_addr >= TBL_OFS) && ({1'b0, reg_addr} < TBL_END);
  assign tbl_rel    = reg_addr - TBL_OFS;
  assign tbl_idx    = tbl_rel[IDX_W+2:3];
  assign tbl_hi     = tbl_rel[2];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_we
    assign lo_we[g] = wr_en && in_tbl && !tbl_hi && (tbl_idx == IDX_W'(g));
    assign hi_we[g] = wr_en && in_tbl &&  tbl_hi && (tbl_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlate_on <= 1'b0;
      size_idx <= SIZE_W'(RESET_SIZE);
    end else begin
      if (wr_en && hit_ctrl) xlate_on <= wdata[1];
      if (size_write)        size_idx <= wdata[SIZE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < NUM_WIN; n++) begin
      if (!rst_n) begin
        win_lo[n] <= '0;
        win_hi[n] <= '0;
      end else begin
        if (lo_we[n]) win_lo[n] <= wdata;
        if (hi_we[n]) win_hi[n] <= wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit_ctrl)
      rd_word = {{(WORD_W-2){1'b0}}, xlate_on, 1'b0};
    else if (reg_addr == SIZE_OFS)
      rd_word = {{(WORD_W-SIZE_W){1'b0}}, size_idx};
    else if (in_tbl)
      rd_word = tbl_hi ? win_hi[tbl_idx] : win_lo[tbl_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/otw_lookup.sv
module otw_lookup
  import otw_pkg::*;
#(
  parameter int NUM_WIN = 32
) (
  input  word_t                          req_offset,
  input  size_t                          size_idx,
  input  logic [NUM_WIN-1:0][WORD_W-1:0] win_lo,
  input  logic [NUM_WIN-1:0][WORD_W-1:0] win_hi,
  output logic                           in_range,
  output logic                           win_open,
  output link_t                          link
);
  localparam int IDX_W = $clog2(NUM_WIN);

  word_t            number, inner;
  logic [IDX_W-1:0] sel;

  assign number   = win_number(req_offset, size_idx);
  assign inner    = win_inner(req_offset, size_idx);
  assign in_range = (number < word_t'(NUM_WIN));
  assign sel      = number[IDX_W-1:0];
  assign win_open = in_range && win_lo[sel][0];
  assign link     = link_addr(win_hi[sel], win_lo[sel], inner);
endmodule

// File: rtl/otw_resp.sv
module otw_resp
  import otw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_fault,
  input  link_t link,
  output logic  rsp_valid,
  output logic  rsp_err,
  output link_t rsp_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && req_fault;
      rsp_addr  <= (req_valid && !req_fault) ? link : '0;
    end
  end
endmodule

// File: rtl/otw_xlate.sv
module otw_xlate
  import otw_pkg::*;
#(
  parameter int NUM_WIN    = 32,
  parameter int REG_AW     = 12,
  parameter int RESET_SIZE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_offset,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_addr
);
  logic                           xlate_on, size_write, in_range, win_open, req_fault;
  size_t                          size_idx;
  link_t                          link;
  logic [NUM_WIN-1:0][WORD_W-1:0] win_lo, win_hi;

  otw_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .RESET_SIZE(RESET_SIZE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wdata(wdata), .rdata(rdata), .xlate_on(xlate_on), .size_idx(size_idx),
    .size_write(size_write), .win_lo(win_lo), .win_hi(win_hi)
  );

  otw_lookup #(.NUM_WIN(NUM_WIN)) u_lookup (
    .req_offset(req_offset), .size_idx(size_idx), .win_lo(win_lo), .win_hi(win_hi),
    .in_range(in_range), .win_open(win_open), .link(link)
  );

  assign req_fault = !xlate_on || !win_open;

  otw_resp u_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fault(req_fault),
    .link(link), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr)
  );
endmodule

// File: rtl/otw_xlate_chk.sv
module otw_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_addr,
  input logic        xlate_on,
  input logic        in_range,
  input logic        win_open,
  input logic        size_write,
  input logic [2:0]  size_idx
);
  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_off_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xlate_on |=> rsp_err);
  p_closed_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_range && !win_open |=> rsp_err);
  p_range_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !in_range |=> rsp_err);
  p_err_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_addr == 64'd0);
  p_size_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !size_write |=> $stable(size_idx));
endmodule

bind otw_xlate otw_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_addr(rsp_addr), .xlate_on(xlate_on),
  .in_range(in_range), .win_open(win_open), .size_write(size_write),
  .size_idx(size_idx)
);

// File: tb/otw_xlate_bench.sv
module otw_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, req_valid = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] wdata = '0, req_offset = '0, rdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_addr;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  otw_xlate u_otw_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wdata(wdata), .rdata(rdata), .req_valid(req_valid), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr)
  );

  // Vectors with 8 MB windows, translation on. Each entry: offset, error, address.
  localparam int NV = 9;
  localparam logic [31:0] V_OFF [NV] = '{32'h0000_0010, 32'h007F_FFFF, 32'h0080_0000,
    32'h0080_0004, 32'h0280_0000, 32'h0F80_0008, 32'h1000_0000, 32'h0100_0000, 32'h01A0_0000};
  localparam bit V_ERR [NV] = '{0, 0, 0, 0, 1, 0, 1, 1, 0};
  localparam logic [63:0] V_ADR [NV] = '{64'h1_4000_0010, 64'h1_407F_FFFF, 64'h2_8000_0000,
    64'h2_8000_0004, 64'h0, 64'hA_F000_0008, 64'h0, 64'h0, 64'h8_0010_0000};
  localparam string V_REQ [NV] = '{"R5", "R4", "R4", "R5", "R6", "R5", "R8", "R6", "R5"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; reg_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic send(input logic [31:0] off);
    @(negedge clk); req_valid = 1'b1; req_offset = off;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input bit e, input logic [63:0] a);
    check(req, {63'd0, rsp_valid}, 64'd1);
    check(req, {63'd0, rsp_err}, {63'd0, e});
    check(req, rsp_addr, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check("R1", {63'd0, rsp_valid}, 64'd0);
    reg_read(12'h004, d); check("R1", {32'd0, d}, 64'd0);
    reg_read(12'h030, d); check("R1", {32'd0, d}, 64'd3);
    reg_read(12'h2F8, d); check("R1", {32'd0, d}, 64'd0);

    // R2 table setup and readback
    reg_write(12'h200, 32'h4000_0001); reg_write(12'h204, 32'h1);
    reg_write(12'h208, 32'h8000_0001); reg_write(12'h20C, 32'h2);
    reg_write(12'h218, 32'hFFF0_0001); reg_write(12'h21C, 32'h7);
    reg_write(12'h228, 32'h1234_0000); reg_write(12'h22C, 32'h5);
    reg_write(12'h2F8, 32'hF000_0001); reg_write(12'h2FC, 32'hA);
    reg_read(12'h2FC, d); check("R2", {32'd0, d}, 64'hA);
    reg_read(12'h228, d); check("R2", {32'd0, d}, 64'h1234_0000);

    // R7 translation off refuses requests
    send(32'h0000_0010); expect_rsp("R7", 1'b1, 64'h0);

    // R2 enable bit only, unused bits read zero
    reg_write(12'h004, 32'hFFFF_FFFF);
    reg_read(12'h004, d); check("R2", {32'd0, d}, 64'h2);
    // R2 unmapped address: write ignored, reads zero
    reg_write(12'h100, 32'hDEAD_BEEF);
    reg_read(12'h100, d); check("R2", {32'd0, d}, 64'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      send(V_OFF[i]);
      expect_rsp(V_REQ[i], V_ERR[i], V_ADR[i]);
    end

    // R3 response lasts one cycle
    @(negedge clk); check("R3", {63'd0, rsp_valid}, 64'd0);

    // R4 size index 4 -> 16 MB windows
    reg_write(12'h030, 32'h4);
    send(32'h0080_0000); expect_rsp("R4", 1'b0, 64'h1_4080_0000);

    // R9 size write and request in the same cycle: old size applies
    @(negedge clk);
    wr_en = 1'b1; reg_addr = 12'h030; wdata = 32'h0;
    req_valid = 1'b1; req_offset = 32'h0010_0000;
    @(negedge clk); wr_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R9", 1'b0, 64'h1_4010_0000);
    // R9 next request sees 1 MB windows
    send(32'h0010_0000); expect_rsp("R9", 1'b0, 64'h2_8000_0000);
    // R8 with 1 MB windows, window 32 is out of range
    send(32'h0200_0000); expect_rsp("R8", 1'b1, 64'h0);

    // R7 disabling translation again
    reg_write(12'h004, 32'h0);
    send(32'h0010_0000); expect_rsp("R7", 1'b1, 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule